// File: doc/BRIEF.md
# Port Pin Interrupt Generator

This block turns activity on one input port into an interrupt request for a chained interrupt scheme. Software sets it up through a stream of byte writes on one control path. An even byte is kept as the interrupt vector. An odd byte with a particular low nibble selects the interrupt mode, and that byte may say that the next write is a pin mask. The block samples the port pins through a synchroniser. It raises a request when the masked pins first meet the programmed condition. The request stays up until the acknowledge for this port completes.

The request and the stored vector go to a priority chain node outside this block. That node arbitrates with other sources and places the vector on the bus. The block does no handshake transfers and decodes no other bus traffic.

Top module: `pio_pin_irq`

## Requirements
- R1: After a synchronous reset, `irq` is 0, `vector` is 00h and the interrupt is disabled. Pin activity then raises no request.
- R2: A control write with bit 0 = 0, when no mask is awaited, stores the whole byte. It appears on `vector` after the next clock edge.
- R3: A control write whose bits [3:0] are 0111 is a mode byte. Bit 7 = 1 enables the interrupt. Bit 6 selects the combine rule: 0 fires when any selected pin matches, 1 fires only when all selected pins match. Bit 5 selects the level: 0 tests for high, 1 tests for low. Bit 4 = 1 makes the next write a mask.
- R4: When a mask is awaited, the next control write is taken whole as the pin mask, whatever its bit 0 or low nibble. `vector` stays unchanged. A mask bit of 1 selects that pin by default.
- R5: Writing 97h and then FFh makes a request follow any single pin going high. `irq` rises on the third rising clock edge after the pin change, not on the second.
- R6: In all-pins mode, a request needs every selected pin to match. A partial match raises nothing.
- R7: In low mode, a selected pin going low raises a request.
- R8: Pins outside the mask have no effect on the request.
- R9: A request is raised only when the condition becomes true. After it is acknowledged, a condition that stays true raises no new request. The condition must go false and then true again.
- R10: A raised request stays high until `ack_done` is pulsed. It then clears on the next clock edge.
- R11: A mode byte with bit 7 = 0 disables the interrupt and drops any pending request within two clock edges. While disabled, pin changes raise nothing.
- R12: An odd control byte whose low nibble is not 0111 is ignored when no mask is awaited. `vector` and the mode are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe, one cycle per byte |
| ctl_data | input | 8 | Control write byte |
| pins | input | 8 | Asynchronous port input pins |
| ack_done | input | 1 | Pulse when the acknowledge cycle for this port completes |
| irq | output | 1 | Registered interrupt request |
| vector | output | 8 | Stored interrupt vector |

## Verification
The bench aims at the mask byte that looks like a vector or a mode byte. A decoder that checked the encoding before the mask-awaited flag would overwrite `vector` or change the mode. It holds the condition true across an acknowledge, because a level-triggered design would raise the request again at once. It uses excluded pins and partial matches in all-pins mode, which catch a mask of the wrong polarity or a rule that ORs where it should AND. It also checks the exact latency and that disabling drops a pending request. An off-by-one synchroniser, or a request left stuck when the interrupt is turned off, would show there.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;
  localparam logic [3:0] MODE_TAG = 4'b0111;

  typedef struct packed {
    logic en;        // interrupt enabled
    logic all_mode;  // 1: every selected pin must match
    logic low_act;   // 1: test for low level
  } irq_cfg_t;
endpackage

// File: rtl/pio_ctl_decode.sv
module pio_ctl_decode
  import pio_irq_pkg::*;
#(
  parameter int CTL_W        = 8,
  parameter int PORT_W       = 8,
  parameter bit MASK_SEL_ONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTL_W-1:0]  data,
  output irq_cfg_t          cfg_q,
  output logic [PORT_W-1:0] mask_q,
  output logic [CTL_W-1:0]  vec_q,
  output logic              mask_pend
);
  localparam logic [PORT_W-1:0] MASK_ALL = MASK_SEL_ONE ? '1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      mask_q    <= MASK_ALL;
      vec_q     <= '0;
      mask_pend <= 1'b0;
    end else if (wr) begin
      if (mask_pend) begin
        mask_q    <= data[PORT_W-1:0];
        mask_pend <= 1'b0;
      end else if (!data[0]) begin
        vec_q <= data;
      end else if (data[3:0] == MODE_TAG) begin
        cfg_q.en       <= data[7];
        cfg_q.all_mode <= data[6];
        cfg_q.low_act  <= data[5];
        mask_pend      <= data[4];
      end
    end
  end
endmodule

// File: rtl/pio_pin_sync.sv
module pio_pin_sync #(
  parameter int PORT_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pins,
  output logic [PORT_W-1:0] pins_s
);
  logic [STAGES-1:0][PORT_W-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pins_s = chain[STAGES-1];
endmodule

// File: rtl/pio_cond_eval.sv
module pio_cond_eval
  import pio_irq_pkg::*;
#(
  parameter int PORT_W       = 8,
  parameter bit MASK_SEL_ONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  irq_cfg_t          cfg,
  input  logic [PORT_W-1:0] mask,
  input  logic [PORT_W-1:0] pins_s,
  input  logic              ack,
  output logic              irq
);
  logic [PORT_W-1:0] sel, act, hit;
  logic cond, cond_q, fire, pend;

  assign sel  = MASK_SEL_ONE ? mask : ~mask;
  assign act  = cfg.low_act ? ~pins_s : pins_s;
  assign hit  = act & sel;

  always_comb begin
    if (cfg.all_mode) cond = (hit == sel) && (|sel);
    else              cond = |hit;
  end

  assign fire = cond & ~cond_q & cfg.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      cond_q <= cond;
      if (!cfg.en) pend <= 1'b0;
      else         pend <= (pend & ~ack) | fire;
    end
  end

  assign irq = pend;
endmodule

// File: rtl/pio_pin_irq.sv
module pio_pin_irq
  import pio_irq_pkg::*;
#(
  parameter int CTL_W        = 8,
  parameter int PORT_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter bit MASK_SEL_ONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_data,
  input  logic [PORT_W-1:0] pins,
  input  logic              ack_done,
  output logic              irq,
  output logic [CTL_W-1:0]  vector
);
  irq_cfg_t          cfg_q;
  logic [PORT_W-1:0] mask_q, pins_s;
  logic              mask_pend;
  logic              cfg_en;

  assign cfg_en = cfg_q.en;

  pio_ctl_decode #(.CTL_W(CTL_W), .PORT_W(PORT_W), .MASK_SEL_ONE(MASK_SEL_ONE)) u_dec (
    .clk(clk), .rst(rst), .wr(ctl_wr), .data(ctl_data),
    .cfg_q(cfg_q), .mask_q(mask_q), .vec_q(vector), .mask_pend(mask_pend)
  );

  pio_pin_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pins(pins), .pins_s(pins_s)
  );

  pio_cond_eval #(.PORT_W(PORT_W), .MASK_SEL_ONE(MASK_SEL_ONE)) u_eval (
    .clk(clk), .rst(rst), .cfg(cfg_q), .mask(mask_q), .pins_s(pins_s),
    .ack(ack_done), .irq(irq)
  );
endmodule

// File: rtl/pio_pin_irq_chk.sv
module pio_pin_irq_chk #(
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_data,
  input logic             ack_done,
  input logic             irq,
  input logic [CTL_W-1:0] vector,
  input logic             en,
  input logic             mask_pend
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!irq && vector == '0));

  assert_vec_store_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !mask_pend && !ctl_data[0]) |=> (vector == $past(ctl_data)));

  assert_mask_take_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && mask_pend) |=> (!mask_pend && $stable(vector)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && en && !ack_done &&
     !(ctl_wr && !mask_pend && ctl_data[3:0] == 4'b0111 && !ctl_data[7])) |=> irq);

  assert_enabled_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(en));

  assert_odd_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !mask_pend && ctl_data[0] && ctl_data[3:0] != 4'b0111)
      |=> ($stable(vector) && $stable(en) && !mask_pend));
endmodule

bind pio_pin_irq pio_pin_irq_chk #(.CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .ack_done(ack_done), .irq(irq), .vector(vector),
  .en(cfg_en), .mask_pend(mask_pend)
);

// File: tb/pio_pin_irq_test.sv
module pio_pin_irq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = '0;
  logic [7:0] pins = '0;
  logic       ack_done = 1'b0;
  logic       irq;
  logic [7:0] vector;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_pin_irq uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .pins(pins), .ack_done(ack_done), .irq(irq), .vector(vector)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = b;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk);
    pins = p;
  endtask

  task automatic ack();
    @(negedge clk);
    ack_done = 1'b1;
    @(negedge clk);
    ack_done = 1'b0;
  endtask

  task automatic t_reset();
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(vector == 8'h00, "R1 vector after reset", vector, 0);
    set_pins(8'hFF); tick(5);
    check(irq == 1'b0, "R1 disabled after reset", irq, 0);
    set_pins(8'h00); tick(4);
  endtask

  task automatic t_vector();
    wr(8'h42);
    check(vector == 8'h42, "R2 vector stored", vector, 8'h42);
    wr(8'h8F);
    tick(1);
    check(vector == 8'h42, "R12 odd byte ignored", vector, 8'h42);
    set_pins(8'hFF); tick(5);
    check(irq == 1'b0, "R12 odd byte did not enable", irq, 0);
    set_pins(8'h00); tick(4);
  endtask

  task automatic t_or_high();
    wr(8'h97); wr(8'hFF); tick(2);
    set_pins(8'h10); tick(2);
    check(irq == 1'b0, "R5 not before third edge", irq, 0);
    tick(1);
    check(irq == 1'b1, "R5 raised on third edge", irq, 1);
    tick(6);
    check(irq == 1'b1, "R10 held until ack", irq, 1);
    ack();
    check(irq == 1'b0, "R10 cleared by ack", irq, 0);
    tick(6);
    check(irq == 1'b0, "R9 no refire while true", irq, 0);
    set_pins(8'h00); tick(4);
    set_pins(8'h01); tick(4);
    check(irq == 1'b1, "R9 new edge fires", irq, 1);
    ack(); set_pins(8'h00); tick(4);
  endtask

  task automatic t_mask();
    wr(8'h97); wr(8'h01); tick(3);
    set_pins(8'hFE); tick(5);
    check(irq == 1'b0, "R8 excluded pins ignored", irq, 0);
    set_pins(8'hFF); tick(4);
    check(irq == 1'b1, "R8 selected pin fires", irq, 1);
    ack(); set_pins(8'h00); tick(4);
    wr(8'h97); wr(8'h02); tick(1);
    check(vector == 8'h42, "R4 even mask not a vector", vector, 8'h42);
    set_pins(8'h02); tick(4);
    check(irq == 1'b1, "R4 mask 02h selects pin 1", irq, 1);
    ack(); set_pins(8'h00); tick(4);
  endtask

  task automatic t_and_high();
    wr(8'hD7); wr(8'h0F); tick(3);
    set_pins(8'h07); tick(5);
    check(irq == 1'b0, "R6 partial match no fire", irq, 0);
    set_pins(8'h0F); tick(4);
    check(irq == 1'b1, "R6 full match fires", irq, 1);
    ack(); set_pins(8'h00); tick(4);
  endtask

  task automatic t_disable_low();
    wr(8'h97); wr(8'hFF); tick(3);
    set_pins(8'h80); tick(4);
    check(irq == 1'b1, "R11 setup request", irq, 1);
    wr(8'h07); tick(2);
    check(irq == 1'b0, "R11 disable drops request", irq, 0);
    set_pins(8'h00); tick(3); set_pins(8'hFF); tick(5);
    check(irq == 1'b0, "R11 no request while disabled", irq, 0);
    wr(8'hB7); wr(8'h30); tick(4);
    check(irq == 1'b0, "R7 pins high no fire", irq, 0);
    set_pins(8'hEF); tick(4);
    check(irq == 1'b1, "R7 low pin fires", irq, 1);
    check(vector == 8'h42, "R3 vector untouched by mode", vector, 8'h42);
    ack(); tick(2);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_vector();
    t_or_high();
    t_mask();
    t_and_high();
    t_disable_low();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule